// File: doc/BRIEF.md
# Mode-Select 4-Bit ALU Slice

This block is a purely combinational arithmetic and logic slice, four bits wide. A mode input chooses between a logic mode, where every result bit is a Boolean function of the matching operand bits alone, and an arithmetic mode, where the bits are linked through a carry chain. A four-bit select code then picks the function within the chosen mode. All sixteen select codes are decoded in both modes. The codes listed below are the ones the block guarantees as named functions.

The carry input and the carry output are both active low. Wider adders are built by wiring the carry output of one slice straight into the carry input of the next. For faster chains, the slice also gives active-low group generate and group propagate terms that an external lookahead unit can use. An all-ones flag is high whenever the result is 1111. With the subtract-minus-one function, this flag shows that the two operands are equal.

Top module: `nibble_alu`

## Requirements
- R1: Arithmetic mode (mode=0) with select 1001 gives result = (A + B + cin) mod 16, where cin = 1 when carry_n_i = 0 and cin = 0 when carry_n_i = 1.
- R2: Arithmetic mode with select 0110 gives A minus B when carry_n_i = 0 and A minus B minus 1 when carry_n_i = 1, both modulo 16.
- R3: Arithmetic mode with select 1111 gives A minus 1 when carry_n_i = 1 and A unchanged when carry_n_i = 0.
- R4: Logic mode (mode=1) gives: select 1011 → A AND B, select 1110 → A OR B, select 0110 → A XOR B, select 0100 → NOT(A AND B), select 0001 → NOT(A OR B).
- R5: In logic mode the result does not depend on carry_n_i, for every select code.
- R6: Select 0000 gives NOT A in logic mode, and A plus cin in arithmetic mode.
- R7: For every select code in arithmetic mode, the result with carry_n_i = 0 equals the result with carry_n_i = 1 plus one, modulo 16.
- R8: carry_n_o is low exactly when the full arithmetic value overflows four bits. The full value is A+B+cin for select 1001, A+(15−B)+cin for select 0110, A+15+cin for select 1111, and A+cin for select 0000.
- R9: all_ones_o is high exactly when the result is 1111. In particular, select 0110 with carry_n_i = 1 and A = B raises it.
- R10: Per bit, p = A | (B & S0) | (~B & S1) and g = (A & B & S3) | (A & ~B & S2), where S0 is the lsb of the select. gen_n_o = NOT(g3 | p3g2 | p3p2g1 | p3p2p1g0) and prop_n_o = NOT(p3 & p2 & p1 & p0). Both are independent of the mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 4 | First operand |
| b_i | input | 4 | Second operand |
| sel_i | input | 4 | Function select code |
| mode_i | input | 1 | 1 = logic mode, 0 = arithmetic mode |
| carry_n_i | input | 1 | Active-low carry input |
| f_o | output | 4 | Result |
| all_ones_o | output | 1 | High when the result is 1111 |
| carry_n_o | output | 1 | Active-low carry output |
| gen_n_o | output | 1 | Active-low group generate |
| prop_n_o | output | 1 | Active-low group propagate |

## Verification
Two things can happen in one evaluation: a carry out of the top bit, and an all-ones result from the same operand pair. The boundary is sharp at the equal-operand subtract. With carry_n_i = 1 the result is 1111 with no carry out. With carry_n_i = 0 the result wraps to 0000 and the carry comes out. The bench applies both versions of each equal-operand and near-overflow pair, mixed with seeded random operands over all select codes. For each stimulus it compares the result, the carry output, the flag and the lookahead terms against values it computes itself.

// File: rtl/nibble_alu_pkg.sv
package nibble_alu_pkg;

    localparam int SLICE_W = 4;
    localparam int SEL_W   = 4;

    typedef logic [SEL_W-1:0] sel_t;

    typedef enum logic {
        MODE_ARITH = 1'b0,
        MODE_LOGIC = 1'b1
    } mode_e;

    // Named select codes
    localparam sel_t SEL_PASS = 4'b0000;
    localparam sel_t SEL_NOR  = 4'b0001;
    localparam sel_t SEL_NAND = 4'b0100;
    localparam sel_t SEL_SUB  = 4'b0110;
    localparam sel_t SEL_XOR  = 4'b0110;
    localparam sel_t SEL_ADD  = 4'b1001;
    localparam sel_t SEL_AND  = 4'b1011;
    localparam sel_t SEL_OR   = 4'b1110;
    localparam sel_t SEL_DEC  = 4'b1111;

    // Per-bit terms: propagate, generate and half-sum
    typedef struct packed {
        logic prop;
        logic gen;
        logic half;
    } cell_t;

    function automatic cell_t cell_eval(input logic a, input logic b, input sel_t s);
        cell_t c;
        c.prop = a | (b & s[0]) | (~b & s[1]);
        c.gen  = (a & b & s[3]) | (a & ~b & s[2]);
        c.half = c.prop & ~c.gen;
        return c;
    endfunction

    function automatic logic chain_next(input cell_t c, input logic cin);
        return c.gen | (c.prop & cin);
    endfunction

endpackage

// File: rtl/nibble_alu_cells.sv
module nibble_alu_cells
    import nibble_alu_pkg::*;
#(
    parameter int WIDTH = SLICE_W
) (
    input  logic [WIDTH-1:0]        a_i,
    input  logic [WIDTH-1:0]        b_i,
    input  sel_t                    sel_i,
    output cell_t [WIDTH-1:0]       cells_o
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign cells_o[i] = cell_eval(a_i[i], b_i[i], sel_i);
    end
endmodule

// File: rtl/nibble_alu_carry.sv
module nibble_alu_carry
    import nibble_alu_pkg::*;
#(
    parameter int WIDTH = SLICE_W
) (
    input  cell_t [WIDTH-1:0]  cells_i,
    input  logic               cin_i,       // active high
    output logic [WIDTH-1:0]   carry_in_o,  // carry into each bit
    output logic               cout_o,      // active high
    output logic               grp_gen_o,
    output logic               grp_prop_o
);
    logic [WIDTH:0] chain;

    always_comb begin
        chain[0] = cin_i;
        for (int i = 0; i < WIDTH; i++) begin
            chain[i+1] = chain_next(cells_i[i], chain[i]);
        end
    end

    always_comb begin
        logic gg;
        logic gp;
        gg = 1'b0;
        gp = 1'b1;
        for (int i = 0; i < WIDTH; i++) begin
            gg = cells_i[i].gen | (cells_i[i].prop & gg);
            gp = gp & cells_i[i].prop;
        end
        grp_gen_o  = gg;
        grp_prop_o = gp;
    end

    assign carry_in_o = chain[WIDTH-1:0];
    assign cout_o     = chain[WIDTH];
endmodule

// File: rtl/nibble_alu_result.sv
module nibble_alu_result
    import nibble_alu_pkg::*;
#(
    parameter int WIDTH = SLICE_W
) (
    input  cell_t [WIDTH-1:0]  cells_i,
    input  logic [WIDTH-1:0]   carry_in_i,
    input  mode_e              mode_i,
    output logic [WIDTH-1:0]   f_o,
    output logic               all_ones_o
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_res
        always_comb begin
            if (mode_i == MODE_LOGIC) begin
                f_o[i] = ~cells_i[i].half;
            end else begin
                f_o[i] = cells_i[i].half ^ carry_in_i[i];
            end
        end
    end

    assign all_ones_o = &f_o;
endmodule

// File: rtl/nibble_alu.sv
module nibble_alu
    import nibble_alu_pkg::*;
#(
    parameter int WIDTH = SLICE_W
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             mode_i,
    input  logic             carry_n_i,
    output logic [WIDTH-1:0] f_o,
    output logic             all_ones_o,
    output logic             carry_n_o,
    output logic             gen_n_o,
    output logic             prop_n_o
);
    cell_t [WIDTH-1:0] cells;
    logic  [WIDTH-1:0] bit_carry;
    logic              cout;
    logic              grp_gen;
    logic              grp_prop;
    mode_e             mode;

    assign mode = mode_e'(mode_i);

    nibble_alu_cells #(.WIDTH(WIDTH)) cells_i (
        .a_i     (a_i),
        .b_i     (b_i),
        .sel_i   (sel_t'(sel_i)),
        .cells_o (cells)
    );

    nibble_alu_carry #(.WIDTH(WIDTH)) carry_i (
        .cells_i    (cells),
        .cin_i      (~carry_n_i),
        .carry_in_o (bit_carry),
        .cout_o     (cout),
        .grp_gen_o  (grp_gen),
        .grp_prop_o (grp_prop)
    );

    nibble_alu_result #(.WIDTH(WIDTH)) result_i (
        .cells_i    (cells),
        .carry_in_i (bit_carry),
        .mode_i     (mode),
        .f_o        (f_o),
        .all_ones_o (all_ones_o)
    );

    assign carry_n_o = ~cout;
    assign gen_n_o   = ~grp_gen;
    assign prop_n_o  = ~grp_prop;
endmodule

// File: rtl/nibble_alu_chk.sv
module nibble_alu_chk
    import nibble_alu_pkg::*;
#(
    parameter int WIDTH = SLICE_W
) (
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic [SEL_W-1:0] sel_i,
    input logic             mode_i,
    input logic             carry_n_i,
    input logic [WIDTH-1:0] f_o,
    input logic             all_ones_o,
    input logic             carry_n_o,
    input logic             gen_n_o,
    input logic             prop_n_o
);
    logic [WIDTH:0] cin_w;
    logic [WIDTH:0] full_add;
    logic [WIDTH:0] full_sub;
    logic [WIDTH:0] full_dec;
    logic [WIDTH:0] full_pass;

    always_comb begin
        cin_w     = {{WIDTH{1'b0}}, ~carry_n_i};
        full_add  = {1'b0, a_i} + {1'b0, b_i} + cin_w;
        full_sub  = {1'b0, a_i} + {1'b0, ~b_i} + cin_w;
        full_dec  = {1'b0, a_i} + {1'b0, {WIDTH{1'b1}}} + cin_w;
        full_pass = {1'b0, a_i} + cin_w;
    end

    always_comb begin
        if (!mode_i && sel_i == SEL_ADD)
            a_r1_add: assert ({~carry_n_o, f_o} == full_add);
        if (!mode_i && sel_i == SEL_SUB)
            a_r2_sub: assert ({~carry_n_o, f_o} == full_sub);
        if (!mode_i && sel_i == SEL_DEC)
            a_r3_dec: assert ({~carry_n_o, f_o} == full_dec);
        if (mode_i && sel_i == SEL_AND)
            a_r4_and: assert (f_o == (a_i & b_i));
        if (mode_i && sel_i == SEL_XOR)
            a_r4_xor: assert (f_o == (a_i ^ b_i));
        if (!mode_i && sel_i == SEL_PASS)
            a_r6_pass: assert ({~carry_n_o, f_o} == full_pass);
        if (mode_i && sel_i == SEL_PASS)
            a_r6_not: assert (f_o == ~a_i);
        if (!mode_i && sel_i == SEL_SUB && carry_n_i && a_i == b_i)
            a_r9_equal: assert (all_ones_o);
        if (!gen_n_o)
            a_r10_gen_carry: assert (!carry_n_o);
        if (!prop_n_o && !carry_n_i)
            a_r10_prop_carry: assert (!carry_n_o);
    end
endmodule

bind nibble_alu nibble_alu_chk #(.WIDTH(WIDTH)) chk_i (.*);

// File: tb/nibble_alu_tb_top.sv
module nibble_alu_tb_top;

    logic       clk;
    logic [3:0] a, b, sel;
    logic       mode, cn;
    logic [3:0] f;
    logic       all_ones, cn_out, gen_n, prop_n;

    int checks;
    int errors;
    int cycles;

    initial clk = 1'b0;
    always #5 clk = ~clk;

    nibble_alu dut_i (
        .a_i        (a),
        .b_i        (b),
        .sel_i      (sel),
        .mode_i     (mode),
        .carry_n_i  (cn),
        .f_o        (f),
        .all_ones_o (all_ones),
        .carry_n_o  (cn_out),
        .gen_n_o    (gen_n),
        .prop_n_o   (prop_n)
    );

    // Full arithmetic value (R1, R2, R3, R6, R8); bit 4 is the carry
    function automatic logic [4:0] ref_arith(input logic [3:0] s, input logic [3:0] x,
                                             input logic [3:0] y, input logic c_n);
        logic [4:0] ci;
        ci = {4'd0, ~c_n};
        case (s)
            4'b1001: return {1'b0, x} + {1'b0, y} + ci;
            4'b0110: return {1'b0, x} + {1'b0, 4'd15 - y} + ci;
            4'b1111: return {1'b0, x} + 5'd15 + ci;
            default: return {1'b0, x} + ci;
        endcase
    endfunction

    function automatic logic is_named_arith(input logic [3:0] s);
        return s == 4'b1001 || s == 4'b0110 || s == 4'b1111 || s == 4'b0000;
    endfunction

    // Logic functions (R4, R6)
    function automatic logic [3:0] ref_logic(input logic [3:0] s, input logic [3:0] x,
                                             input logic [3:0] y);
        case (s)
            4'b1011: return x & y;
            4'b1110: return x | y;
            4'b0110: return x ^ y;
            4'b0100: return ~(x & y);
            4'b0001: return ~(x | y);
            default: return ~x;
        endcase
    endfunction

    function automatic logic is_named_logic(input logic [3:0] s);
        return s == 4'b1011 || s == 4'b1110 || s == 4'b0110 ||
               s == 4'b0100 || s == 4'b0001 || s == 4'b0000;
    endfunction

    // Lookahead terms from R10; returns {gen_n, prop_n}
    function automatic logic [1:0] ref_gp(input logic [3:0] s, input logic [3:0] x,
                                          input logic [3:0] y);
        logic [3:0] p, g;
        for (int i = 0; i < 4; i++) begin
            p[i] = x[i] | (y[i] & s[0]) | (~y[i] & s[1]);
            g[i] = (x[i] & y[i] & s[3]) | (x[i] & ~y[i] & s[2]);
        end
        return {~(g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1]) | (p[3] & p[2] & p[1] & g[0])),
                ~(&p)};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s a=%h b=%h sel=%b mode=%b cn=%b actual=%h expected=%h",
                     req, a, b, sel, mode, cn, act, exp);
        end
    endtask

    task automatic apply(input logic [3:0] x, input logic [3:0] y, input logic [3:0] s,
                         input logic m, input logic c_n);
        @(negedge clk);
        a = x; b = y; sel = s; mode = m; cn = c_n;
        #1;
    endtask

    // Full check of the current stimulus against the requirements
    task automatic judge();
        logic [4:0] av;
        logic [1:0] gp;
        gp = ref_gp(sel, a, b);
        check("R10", {6'd0, gen_n, prop_n}, {6'd0, gp});
        check("R9", {7'd0, all_ones}, {7'd0, f == 4'hF});
        if (!mode && is_named_arith(sel)) begin
            av = ref_arith(sel, a, b, cn);
            check(sel == 4'b1001 ? "R1" : sel == 4'b0110 ? "R2" :
                  sel == 4'b1111 ? "R3" : "R6", {4'd0, f}, {4'd0, av[3:0]});
            check("R8", {7'd0, cn_out}, {7'd0, ~av[4]});
        end
        if (mode && is_named_logic(sel))
            check(sel == 4'b0000 ? "R6" : "R4", {4'd0, f}, {4'd0, ref_logic(sel, a, b)});
    endtask

    // Pair test: both carry-input values for one stimulus (R5, R7)
    task automatic pair(input logic [3:0] x, input logic [3:0] y, input logic [3:0] s,
                        input logic m);
        logic [3:0] f_c1;
        apply(x, y, s, m, 1'b1);
        judge();
        f_c1 = f;
        apply(x, y, s, m, 1'b0);
        judge();
        if (m) check("R5", {4'd0, f}, {4'd0, f_c1});
        else   check("R7", {4'd0, f}, {4'd0, f_c1 + 4'd1});
    endtask

    initial begin
        checks = 0;
        errors = 0;
        a = '0; b = '0; sel = '0; mode = 1'b0; cn = 1'b1;
        @(negedge clk);
        #1;
        // Quiet start: pass-through of zero, no carry, flag low (R6, R8, R9)
        check("R6", {4'd0, f}, 8'd0);
        check("R8", {7'd0, cn_out}, 8'd1);
        check("R9", {7'd0, all_ones}, 8'd0);

        // R1: add near and across the overflow boundary
        pair(4'd7, 4'd8, 4'b1001, 1'b0);
        pair(4'd9, 4'd9, 4'b1001, 1'b0);
        pair(4'd15, 4'd0, 4'b1001, 1'b0);
        // R2, R9: equal-operand subtract, flag vs carry out
        apply(4'd5, 4'd5, 4'b0110, 1'b0, 1'b1);
        check("R9", {7'd0, all_ones}, 8'd1);
        check("R2", {4'd0, f}, 8'h0F);
        check("R8", {7'd0, cn_out}, 8'd1);
        apply(4'd5, 4'd5, 4'b0110, 1'b0, 1'b0);
        check("R2", {4'd0, f}, 8'd0);
        check("R8", {7'd0, cn_out}, 8'd0);
        check("R9", {7'd0, all_ones}, 8'd0);
        pair(4'd3, 4'd9, 4'b0110, 1'b0);
        // R3: decrement of zero and of fifteen
        pair(4'd0, 4'd6, 4'b1111, 1'b0);
        pair(4'd15, 4'd1, 4'b1111, 1'b0);
        // R6: pass and increment of fifteen, NOT A
        pair(4'd15, 4'd2, 4'b0000, 1'b0);
        pair(4'd10, 4'd3, 4'b0000, 1'b1);
        // R4, R5: every named logic function with both carry inputs
        pair(4'hC, 4'hA, 4'b1011, 1'b1);
        pair(4'hC, 4'hA, 4'b1110, 1'b1);
        pair(4'hC, 4'hA, 4'b0110, 1'b1);
        pair(4'hC, 4'hA, 4'b0100, 1'b1);
        pair(4'hC, 4'hA, 4'b0001, 1'b1);
        pair(4'h5, 4'hA, 4'b1110, 1'b1);

        // Seeded random over all codes and both modes (R1..R10)
        begin
            int unsigned seed;
            int unsigned r;
            seed = 32'd20061;
            r = $urandom(seed);
            for (int n = 0; n < 600; n++) begin
                r = $urandom;
                pair(r[3:0], r[7:4], r[11:8], r[12]);
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cycles = 0;
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                checks++;
                errors++;
                $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

endmodule